// File: doc/BRIEF.md
# Dual-Output Programmable Interrupt Controller

This block collects up to `NSRC` peripheral interrupt lines, grouped in banks of 32, and drives two processor request lines: a normal request and a fast request. Software configures each source through a small synchronous register bus. The configuration sets whether the source is level or edge sensitive and which polarity it uses. It also sets whether the source is enabled and which of the two outputs it drives. A software-trigger register lets software inject a request on any source.

The controller keeps raw, enabled and routed status for every source. A vector register reports the lowest-numbered source that is enabled, pending and routed to the normal output, so a handler can find the next source to serve with one read. A master register gates each output on its own. Writes take effect on the clock edge that samples them. Read data appears on `bus_rdata` one cycle after `bus_rd` is sampled and holds until the next read.

Top module: `intc_ctrl`

## Requirements
- R1: After reset, every configuration register reads 0, both outputs are low, and the vector word at 0xD4 reads 0xFFFFFFFF.
- R2: The enable word at 0x10+4*b reads and writes directly. Writing 1s to 0x20+4*b clears those enable bits and writing 1s to 0x30+4*b sets them. Zero bits in either write leave the enables unchanged.
- R3: Source n maps to bank n/32, bit n%32. When its type bit (0x40+4*b) is 0, its raw status (0xA0+4*b) follows the input. A polarity bit (0x50+4*b) of 1 inverts the input, making the source active low.
- R4: When its type bit is 1, a rising edge sets a sticky pending bit; with polarity 1, a falling edge does so instead. The opposite transition does not set it. The bit stays set after the input returns, until a 1 is written to that bit of 0xB0+4*b.
- R5: Writing 1s to 0xC0+4*b sets software-trigger bits, which read back at that address and are ORed into raw status. Writing 0s there has no effect. A trigger bit stays set until a 1 is written to the same bit of 0xB0+4*b.
- R6: A routing bit (0x00+4*b) of 1 sends the source to the fast output and 0 sends it to the normal output. 0x80+4*b reads raw AND enable AND NOT route, and 0x90+4*b reads raw AND enable AND route.
- R7: At 0x64, bit 0 gates the normal output and bit 1 gates the fast output. Each output is a register that goes high one cycle after its master bit and any bit of its routed status are both set.
- R8: Reading 0xD4 returns the lowest source number whose normal status bit is set, or 0xFFFFFFFF when none is set.
- R9: Reading 0xD0 returns the same number as 0xD4 while a source is pending. When none is pending, it returns the last number that was reported.
- R10: Writes to the status words (0x80, 0x90, 0xA0 groups) are ignored. Word slots for banks beyond `NSRC` read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Peripheral interrupt inputs, synchronous to clk |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach is the falling-edge latch on an edge-mode source. Changing polarity or type while the input is steady can itself look like an edge. The stimulus therefore sets polarity first while the source is still level sensitive. It then switches the source to edge mode once the inverted input is already high. Only after that does it drive a rising input, which must not latch, followed by a falling input, which must latch. The last-vector behaviour of 0xD0 is reached in a similar way. Two sources are made pending, the lower one is rerouted to the fast output, and the higher one is then cleared, which leaves a stale number that only 0xD0 may still show.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Register group selected by address bits [7:4]
    typedef enum logic [3:0] {
        K_ROUTE  = 4'h0,
        K_EN     = 4'h1,
        K_ENCLR  = 4'h2,
        K_ENSET  = 4'h3,
        K_TYPE   = 4'h4,
        K_POL    = 4'h5,
        K_MASTER = 4'h6,
        K_NSTAT  = 4'h8,
        K_FSTAT  = 4'h9,
        K_RAW    = 4'hA,
        K_PCLR   = 4'hB,
        K_SOFT   = 4'hC,
        K_VEC    = 4'hD
    } reg_kind_e;

    localparam int unsigned BANK_W = 32;

endpackage

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BANK_W-1:0]   src,
    input  logic                wsel,
    input  reg_kind_e           kind,
    input  logic [BANK_W-1:0]   wdata,
    output logic [BANK_W-1:0]   route_q,
    output logic [BANK_W-1:0]   en_q,
    output logic [BANK_W-1:0]   typ_q,
    output logic [BANK_W-1:0]   pol_q,
    output logic [BANK_W-1:0]   soft_q,
    output logic [BANK_W-1:0]   raw
);

    logic [BANK_W-1:0] inv, inv_q, rise, latch_q, clr_m;

    assign inv   = src ^ pol_q;
    assign rise  = inv & ~inv_q;
    assign clr_m = (wsel && kind == K_PCLR) ? wdata : '0;
    assign raw   = (typ_q & latch_q) | (~typ_q & inv) | soft_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
            en_q    <= '0;
            typ_q   <= '0;
            pol_q   <= '0;
            soft_q  <= '0;
        end else if (wsel) begin
            unique case (kind)
                K_ROUTE: route_q <= wdata;
                K_EN:    en_q    <= wdata;
                K_ENCLR: en_q    <= en_q & ~wdata;
                K_ENSET: en_q    <= en_q | wdata;
                K_TYPE:  typ_q   <= wdata;
                K_POL:   pol_q   <= wdata;
                K_SOFT:  soft_q  <= soft_q | wdata;
                K_PCLR:  soft_q  <= soft_q & ~wdata;
                default: ;
            endcase
        end
    end

    // Edge history and sticky latch; a new edge wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q   <= '0;
            latch_q <= '0;
        end else begin
            inv_q   <= inv;
            latch_q <= typ_q & ((latch_q & ~clr_m) | rise);
        end
    end

    assert_enset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel && kind == K_ENSET) |=> ((en_q & $past(wdata)) == $past(wdata)));

    assert_enclr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel && kind == K_ENCLR) |=> ((en_q & $past(wdata)) == '0));

    assert_pclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel && kind == K_PCLR) |=> ((latch_q & $past(clr_m & ~rise)) == '0));

    assert_soft_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (($past(soft_q) & ~soft_q & ~$past(clr_m)) == '0));

endmodule

// File: rtl/intc_lowest.sv
module intc_lowest #(
    parameter int unsigned N  = 64,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          valid
);

    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = IW'(i);
                valid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
    import intc_pkg::*;
#(
    parameter int unsigned NSRC   = 64,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);

    localparam int unsigned NBANK = NSRC / BANK_W;
    localparam int unsigned VW    = $clog2(NSRC);

    initial begin
        if (NSRC % BANK_W != 0 || NBANK < 1 || NBANK > 4 || ADDR_W < 8)
            $error("intc_ctrl: NSRC must be 32..128 in steps of 32, ADDR_W >= 8");
    end

    logic        hit;
    logic [1:0]  widx;
    reg_kind_e   kind;

    assign hit  = (bus_addr[ADDR_W-1:8] == '0) && (bus_addr[1:0] == 2'b00);
    assign widx = bus_addr[3:2];
    assign kind = reg_kind_e'(bus_addr[7:4]);

    logic [NSRC-1:0] route_v, en_v, typ_v, pol_v, soft_v, raw_v, nstat, fstat;
    logic [31:0] w_route [NBANK];
    logic [31:0] w_en    [NBANK];
    logic [31:0] w_typ   [NBANK];
    logic [31:0] w_pol   [NBANK];
    logic [31:0] w_soft  [NBANK];
    logic [31:0] w_raw   [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [31:0] b_route, b_en, b_typ, b_pol, b_soft, b_raw;

        intc_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (src_in[g*BANK_W +: BANK_W]),
            .wsel    (bus_wr && hit && widx == 2'(g)),
            .kind    (kind),
            .wdata   (bus_wdata),
            .route_q (b_route),
            .en_q    (b_en),
            .typ_q   (b_typ),
            .pol_q   (b_pol),
            .soft_q  (b_soft),
            .raw     (b_raw)
        );

        assign route_v[g*BANK_W +: BANK_W] = b_route;
        assign en_v   [g*BANK_W +: BANK_W] = b_en;
        assign typ_v  [g*BANK_W +: BANK_W] = b_typ;
        assign pol_v  [g*BANK_W +: BANK_W] = b_pol;
        assign soft_v [g*BANK_W +: BANK_W] = b_soft;
        assign raw_v  [g*BANK_W +: BANK_W] = b_raw;
        assign w_route[g] = b_route;
        assign w_en[g]    = b_en;
        assign w_typ[g]   = b_typ;
        assign w_pol[g]   = b_pol;
        assign w_soft[g]  = b_soft;
        assign w_raw[g]   = b_raw;
    end

    assign nstat = raw_v & en_v & ~route_v;
    assign fstat = raw_v & en_v &  route_v;

    logic [VW-1:0] vec_idx, last_q;
    logic          vec_valid;

    intc_lowest #(.N(NSRC)) u_lowest (
        .req   (nstat),
        .idx   (vec_idx),
        .valid (vec_valid)
    );

    logic [1:0] master_q;
    logic       irq_q, fiq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q <= 2'b00;
            last_q   <= '0;
            irq_q    <= 1'b0;
            fiq_q    <= 1'b0;
        end else begin
            if (bus_wr && hit && kind == K_MASTER && widx == 2'd1)
                master_q <= bus_wdata[1:0];
            if (vec_valid)
                last_q <= vec_idx;
            irq_q <= master_q[0] && (|nstat);
            fiq_q <= master_q[1] && (|fstat);
        end
    end

    assign irq_o = irq_q;
    assign fiq_o = fiq_q;

    logic [31:0] vec_d4, vec_d0, rd_word, rdata_q;
    logic [31:0] s_nstat [NBANK];
    logic [31:0] s_fstat [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_stat
        assign s_nstat[g] = nstat[g*BANK_W +: BANK_W];
        assign s_fstat[g] = fstat[g*BANK_W +: BANK_W];
    end

    assign vec_d4 = vec_valid ? 32'(vec_idx) : 32'hFFFF_FFFF;
    assign vec_d0 = vec_valid ? 32'(vec_idx) : 32'(last_q);

    always_comb begin
        rd_word = '0;
        unique case (kind)
            K_MASTER: if (widx == 2'd1) rd_word = {30'd0, master_q};
            K_VEC: begin
                if (widx == 2'd0) rd_word = vec_d0;
                else if (widx == 2'd1) rd_word = vec_d4;
            end
            default: begin
                for (int b = 0; b < NBANK; b++) begin
                    if (widx == 2'(b)) begin
                        unique case (kind)
                            K_ROUTE: rd_word = w_route[b];
                            K_EN:    rd_word = w_en[b];
                            K_TYPE:  rd_word = w_typ[b];
                            K_POL:   rd_word = w_pol[b];
                            K_SOFT:  rd_word = w_soft[b];
                            K_RAW:   rd_word = w_raw[b];
                            K_NSTAT: rd_word = s_nstat[b];
                            K_FSTAT: rd_word = s_fstat[b];
                            default: rd_word = '0;
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= hit ? rd_word : '0;
    end

    assign bus_rdata = rdata_q;

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(master_q[0]));

    assert_fiq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(master_q[1]));

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(raw_v & en_v & ~route_v)));

    assert_vec_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (raw_v[vec_idx] && en_v[vec_idx] && !route_v[vec_idx]));

    assert_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !$past(vec_valid)) |=> (last_q == $past(vec_idx)));

    // typ_v/pol_v/soft_v are visible through readback only
    logic unused_ok;
    assign unused_ok = ^{typ_v, pol_v, soft_v};

endmodule

// File: tb/intc_ctrl_test.sv
module intc_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src = '0;
    logic [11:0]       addr = '0;
    logic              wr = 1'b0;
    logic [31:0]       wdata = '0;
    logic              rd = 1'b0;
    logic [31:0]       rdata;
    logic              irq, fiq;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_ctrl #(.NSRC(NSRC), .ADDR_W(12)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_wdata (wdata),
        .bus_rd    (rd),
        .bus_rdata (rdata),
        .irq_o     (irq),
        .fiq_o     (fiq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd_reg(a, v);
        check(req, v, exp);
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic scrub();
        @(negedge clk);
        src = '0;
        for (int b = 0; b < 2; b++) begin
            wr_reg(12'h010 + 12'(4*b), 32'h0);
            wr_reg(12'h000 + 12'(4*b), 32'h0);
            wr_reg(12'h050 + 12'(4*b), 32'h0);
            wr_reg(12'h040 + 12'(4*b), 32'h0);
            wr_reg(12'h0B0 + 12'(4*b), 32'hFFFF_FFFF);
        end
        wr_reg(12'h064, 32'h0);
        settle();
    endtask

    task automatic t_reset();
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 fiq", {31'd0, fiq}, 32'd0);
        rd_chk("R1 enable", 12'h010, 32'h0);
        rd_chk("R1 route", 12'h004, 32'h0);
        rd_chk("R1 master", 12'h064, 32'h0);
        rd_chk("R1 vector", 12'h0D4, 32'hFFFF_FFFF);
    endtask

    task automatic t_enable();
        wr_reg(12'h010, 32'h0000_00F0);
        rd_chk("R2 enable rw", 12'h010, 32'h0000_00F0);
        wr_reg(12'h030, 32'h0000_0003);
        rd_chk("R2 enable set", 12'h010, 32'h0000_00F3);
        wr_reg(12'h020, 32'h0000_0030);
        rd_chk("R2 enable clear", 12'h010, 32'h0000_00C3);
        wr_reg(12'h034, 32'h8000_0000);
        rd_chk("R2 bank1 set", 12'h014, 32'h8000_0000);
        rd_chk("R2 bank0 untouched", 12'h010, 32'h0000_00C3);
        scrub();
    endtask

    task automatic t_level();
        src[2] = 1'b1;
        rd_chk("R3 level high", 12'h0A0, 32'h0000_0004);
        wr_reg(12'h050, 32'h0000_0004);
        rd_chk("R3 active low idle", 12'h0A0, 32'h0000_0000);
        src[2] = 1'b0;
        rd_chk("R3 active low asserted", 12'h0A0, 32'h0000_0004);
        wr_reg(12'h050, 32'h0);
        src[33] = 1'b1;
        rd_chk("R3 bank mapping", 12'h0A4, 32'h0000_0002);
        rd_chk("R3 bank0 clear", 12'h0A0, 32'h0);
        scrub();
    endtask

    task automatic t_edge();
        wr_reg(12'h040, 32'h0000_0020);
        src[5] = 1'b1;
        settle();
        src[5] = 1'b0;
        settle();
        rd_chk("R4 rising latched", 12'h0A0, 32'h0000_0020);
        wr_reg(12'h0B0, 32'h0000_0020);
        rd_chk("R4 cleared", 12'h0A0, 32'h0);
        wr_reg(12'h054, 32'h0000_0100);
        settle();
        wr_reg(12'h044, 32'h0000_0100);
        settle();
        rd_chk("R4 no false edge", 12'h0A4, 32'h0);
        src[40] = 1'b1;
        settle();
        rd_chk("R4 opposite edge ignored", 12'h0A4, 32'h0);
        src[40] = 1'b0;
        settle();
        rd_chk("R4 falling latched", 12'h0A4, 32'h0000_0100);
        wr_reg(12'h0B4, 32'h0000_0100);
        rd_chk("R4 falling cleared", 12'h0A4, 32'h0);
        scrub();
    endtask

    task automatic t_soft();
        wr_reg(12'h0C0, 32'h0000_0001);
        wr_reg(12'h0C4, 32'h8000_0000);
        rd_chk("R5 raw bank0", 12'h0A0, 32'h0000_0001);
        rd_chk("R5 raw bank1", 12'h0A4, 32'h8000_0000);
        rd_chk("R5 readback", 12'h0C0, 32'h0000_0001);
        wr_reg(12'h0C0, 32'h0);
        rd_chk("R5 zero write no effect", 12'h0A0, 32'h0000_0001);
        wr_reg(12'h0B0, 32'h0000_0001);
        rd_chk("R5 cleared", 12'h0A0, 32'h0);
        scrub();
    endtask

    task automatic t_route_master();
        wr_reg(12'h010, 32'h0000_0003);
        wr_reg(12'h0C0, 32'h0000_0003);
        wr_reg(12'h000, 32'h0000_0002);
        rd_chk("R6 normal status", 12'h080, 32'h0000_0001);
        rd_chk("R6 fast status", 12'h090, 32'h0000_0002);
        settle();
        check("R7 irq gated", {31'd0, irq}, 32'd0);
        check("R7 fiq gated", {31'd0, fiq}, 32'd0);
        wr_reg(12'h064, 32'h1);
        settle();
        check("R7 irq on", {31'd0, irq}, 32'd1);
        check("R7 fiq still off", {31'd0, fiq}, 32'd0);
        wr_reg(12'h064, 32'h2);
        settle();
        check("R7 irq off", {31'd0, irq}, 32'd0);
        check("R7 fiq on", {31'd0, fiq}, 32'd1);
        wr_reg(12'h064, 32'h3);
        wr_reg(12'h020, 32'h0000_0001);
        settle();
        check("R7 irq after disable", {31'd0, irq}, 32'd0);
        check("R7 fiq with both on", {31'd0, fiq}, 32'd1);
        scrub();
    endtask

    task automatic t_vector();
        wr_reg(12'h010, 32'h0000_0008);
        wr_reg(12'h014, 32'h0000_0100);
        wr_reg(12'h0C0, 32'h0000_0008);
        wr_reg(12'h0C4, 32'h0000_0100);
        rd_chk("R8 lowest", 12'h0D4, 32'd3);
        rd_chk("R9 current", 12'h0D0, 32'd3);
        wr_reg(12'h000, 32'h0000_0008);
        rd_chk("R8 fast-routed skipped", 12'h0D4, 32'd40);
        wr_reg(12'h0B4, 32'h0000_0100);
        rd_chk("R8 none pending", 12'h0D4, 32'hFFFF_FFFF);
        rd_chk("R9 last reported", 12'h0D0, 32'd40);
        scrub();
    endtask

    task automatic t_readonly();
        wr_reg(12'h0A0, 32'hFFFF_FFFF);
        wr_reg(12'h080, 32'hFFFF_FFFF);
        rd_chk("R10 raw ignores write", 12'h0A0, 32'h0);
        rd_chk("R10 status ignores write", 12'h080, 32'h0);
        wr_reg(12'h018, 32'hFFFF_FFFF);
        rd_chk("R10 absent bank reads 0", 12'h018, 32'h0);
        rd_chk("R10 bank0 untouched", 12'h010, 32'h0);
        rd_chk("R10 bank1 untouched", 12'h014, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_level();
        t_edge();
        t_soft();
        t_route_master();
        t_vector();
        t_readonly();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule